// File: doc/BRIEF.md
# Lockable Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer with a 16-bit register interface. Software loads a timeout, turns the watchdog on, and must then keep feeding it with a two-word service sequence. If the count reaches zero, the block records a timeout cause and sends a reset request to the chip's reset generator. The countdown advances once per period. A period is a fixed number of strobes from a slow reference clock, and with the default divider a period is half a second on a 32.768 kHz reference.

The timeout field and the enable bit are guarded against runaway software. The timeout is taken only on the first control write after reset. The enable bit can be set but never cleared. Two action bits in the control register let software request a reset on purpose, and one of them also records a software cause. An optional early-warning interrupt fires a programmable number of periods before expiry. Its enable and its period count lock after the first write to that register. Software clears the interrupt by writing 1 to its status bit.

Top module: `wdog_lock`

## Requirements
- R1: After reset, these registers read back as follows: control (offset 0x0) = 0x0030, service (0x2) = 0x0000, cause (0x4) = 0x0000, interrupt control (0x6) = 0x0004, misc (0x8) = 0x0001. Both `irq` and `rst_req` are low.
- R2: The control register holds the timeout T in bits 15:8 and the enable bit in bit 2. The count runs only while enable is 1 and T is nonzero. Each period is REF_DIV `ref_tick` strobes long. Any control write restarts the count at T+1 periods and clears the prescaler.
- R3: A write of 0xAAAA to the service register (0x2) reloads the count to T+1 and clears the prescaler. This happens only if the previous service write was 0x5555 and the count is running. The service register reads back the last value written to it.
- R4: The enable bit is sticky: once it is 1, it stays 1 until reset. Bits 15:8 are taken only from the first control write after reset. Later control writes leave them unchanged.
- R5: Bit 4 of the control register always reads as 1. Writing 0 to it sets the cause register to 0x0001. Writing 0 to bit 5 (stored and read back) also causes a reset request. In both cases `rst_req` pulses high for one cycle, in the cycle after the write.
- R6: A control write that leaves enable at 1 with a timeout field of 0 gives a one-cycle `rst_req` pulse in the cycle after the write.
- R7: When the count goes from 1 to 0, the cause register becomes 0x0002 and `rst_req` pulses for one cycle. The count then stays at 0. Writes to the cause register have no effect. A control write or a valid service reload in the same cycle takes precedence over the decrement.
- R8: The interrupt control register (0x6) has enable in bit 15, status in bit 14 and the warning count P in bits 7:0. The warning is armed when the count starts (control write or reload), and also on a write to 0x6. It is armed only if enable is 1, the count is running, and the count is greater than P. When the count then steps down to P, the status bit and `irq` go high in the cycle after that step.
- R9: Writing 1 to bit 14 of 0x6 clears the status and drops `irq`. A new warning in the same cycle wins over the clear. Bit 15 and bits 7:0 are taken only from the first write to 0x6 after reset.
- R10: Reads of unmapped or odd offsets return 0, and writes to them have no effect. The misc register (0x8) keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per slow reference clock period |
| wr_en | input | 1 | Write strobe for a 16-bit access |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | One-cycle reset request to the system reset generator |

## Verification
A reference model in the bench tracks every register and both outputs on every clock, while the read address sweeps all offsets, mapped and unmapped. The main countdown is run several ways: with a proper service sequence, with a sequence broken by a stray word, and with enable clear so the count must not move. These runs tell a correct reload apart from a reload that ignores the previous word or the running condition. The warning is run with P below the start count, where it must fire, and above it, where it must stay silent. The direct reset paths (software bit, assertion bit, zero timeout) are driven one at a time, so that each cause code and each reset pulse can be traced to its own trigger.

// File: rtl/wdog_lock.sv
module wdog_lock #(
  parameter int          REF_DIV = 16384,
  parameter logic [15:0] SEQ_A   = 16'h5555,
  parameter logic [15:0] SEQ_B   = 16'hAAAA,
  parameter logic [7:0]  PRE_DEF = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(REF_DIV - 1);
  localparam logic [3:0] A_CTL = 4'h0, A_SVC = 4'h2, A_CAU = 4'h4, A_ICT = 4'h6, A_MSC = 4'h8;

  logic [7:0]    tmo, pre;
  logic          en, asrt, ctl_lk, ie, ist, ict_lk, armed, pde, rq;
  logic [8:0]    cnt;
  logic [DW-1:0] div;
  logic [15:0]   svc_q;
  logic [1:0]    cause;

  wire running = en && (tmo != 8'd0);
  wire w_ctl   = wr_en && (addr == A_CTL);
  wire w_svc   = wr_en && (addr == A_SVC);
  wire w_ict   = wr_en && (addr == A_ICT);
  wire w_msc   = wr_en && (addr == A_MSC);

  wire [7:0] n_tmo   = ctl_lk ? tmo : wdata[15:8];
  wire       n_en    = en | wdata[2];
  wire [8:0] n_top   = {1'b0, n_tmo} + 9'd1;
  wire [8:0] top_cnt = {1'b0, tmo} + 9'd1;
  wire       n_ie    = ict_lk ? ie : wdata[15];
  wire [7:0] n_pre   = ict_lk ? pre : wdata[7:0];

  wire reload  = w_svc && (svc_q == SEQ_A) && (wdata == SEQ_B) && running;
  wire counting = running && (cnt != 9'd0) && ref_tick && !w_ctl && !reload;
  wire step    = counting && (div == DIV_LAST);
  wire [8:0] cnt_dec = cnt - 9'd1;
  wire fire    = step && armed && (cnt_dec == {1'b0, pre});
  wire expire  = step && (cnt == 9'd1);
  wire ctl_req = w_ctl && (!wdata[4] || !wdata[5] || (n_en && n_tmo == 8'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo <= '0; en <= 1'b0; asrt <= 1'b1; ctl_lk <= 1'b0;
      cnt <= '0; div <= '0; svc_q <= '0; cause <= '0;
      ie <= 1'b0; pre <= PRE_DEF; ist <= 1'b0; ict_lk <= 1'b0;
      armed <= 1'b0; pde <= 1'b1; rq <= 1'b0;
    end else begin
      rq <= ctl_req || expire;
      if (w_ctl) begin
        tmo    <= n_tmo;
        en     <= n_en;
        asrt   <= wdata[5];
        ctl_lk <= 1'b1;
        cnt    <= n_top;
        div    <= '0;
        armed  <= n_en && (n_tmo != 8'd0) && ie && (n_top > {1'b0, pre});
        if (!wdata[4]) cause <= 2'b01;
      end else if (reload) begin
        cnt   <= top_cnt;
        div   <= '0;
        armed <= ie && (top_cnt > {1'b0, pre});
      end else if (counting) begin
        if (step) begin
          div <= '0;
          cnt <= cnt_dec;
          if (fire) armed <= 1'b0;
          if (expire) cause <= 2'b10;
        end else begin
          div <= div + 1'b1;
        end
      end
      if (w_ict) begin
        ie     <= n_ie;
        pre    <= n_pre;
        ict_lk <= 1'b1;
        armed  <= running && n_ie && (cnt > {1'b0, n_pre});
      end
      if (fire) ist <= 1'b1;
      else if (w_ict && wdata[14]) ist <= 1'b0;
      if (w_svc) svc_q <= wdata;
      if (w_msc) pde <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = {tmo, 2'b00, asrt, 1'b1, 1'b0, en, 2'b00};
      A_SVC:   rdata = svc_q;
      A_CAU:   rdata = {14'd0, cause};
      A_ICT:   rdata = {ie, ist, 6'd0, pre};
      A_MSC:   rdata = {15'd0, pde};
      default: rdata = 16'd0;
    endcase
  end

  assign irq     = ist;
  assign rst_req = rq;
endmodule

// File: rtl/wdog_lock_chk.sv
module wdog_lock_chk #(
  parameter logic [15:0] SEQ_A = 16'h5555,
  parameter logic [15:0] SEQ_B = 16'hAAAA
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        irq,
  input logic        rst_req,
  input logic        en,
  input logic        ctl_lk,
  input logic        armed,
  input logic [7:0]  tmo,
  input logic [8:0]  cnt,
  input logic [15:0] svc_q,
  input logic [1:0]  cause
);
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h0) |=> (cnt == {1'b0, tmo} + 9'd1));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h2 && wdata == SEQ_B && svc_q == SEQ_A && en && tmo != 8'd0)
      |=> (cnt == {1'b0, tmo} + 9'd1));

  p_en_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  p_tmo_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_lk |=> $stable(tmo));

  p_soft_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h0 && !wdata[4]) |=> (rst_req && cause == 2'b01));

  p_zero_tmo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h0 && wdata[2] && wdata[15:8] == 8'd0 && !ctl_lk) |=> rst_req);

  p_cause_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h4 && cnt != 9'd1) |=> $stable(cause));

  p_irq_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(armed));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] || addr > 4'h8) |-> (rdata == 16'd0));
endmodule

bind wdog_lock wdog_lock_chk #(.SEQ_A(SEQ_A), .SEQ_B(SEQ_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .rst_req(rst_req), .en(en), .ctl_lk(ctl_lk),
  .armed(armed), .tmo(tmo), .cnt(cnt), .svc_q(svc_q), .cause(cause)
);

// File: tb/wdog_lock_test.sv
module wdog_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic irq, rst_req;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  wdog_lock #(.REF_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) ref_tick <= (cyc % 3) != 2;

  int m_tmo, m_en, m_asrt, m_lk, m_cnt, m_div, m_svc, m_rc;
  int m_ie, m_pre, m_ist, m_ilk, m_arm, m_pde, m_rq;

  task automatic m_reset();
    m_tmo = 0; m_en = 0; m_asrt = 1; m_lk = 0; m_cnt = 0; m_div = 0; m_svc = 0;
    m_rc = 0; m_ie = 0; m_pre = 4; m_ist = 0; m_ilk = 0; m_arm = 0; m_pde = 1; m_rq = 0;
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_tmo * 256 + m_asrt * 32 + 16 + m_en * 4;
      2: return m_svc;
      4: return m_rc;
      6: return m_ie * 32768 + m_ist * 16384 + m_pre;
      8: return m_pde;
      default: return 0;
    endcase
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int run, wc, ws, wi, wm, ntmo, nen, rl, rq, fire, ocnt, d;
      d = wdata;
      run = (m_en != 0 && m_tmo != 0);
      wc = wr_en && addr == 0; ws = wr_en && addr == 2;
      wi = wr_en && addr == 6; wm = wr_en && addr == 8;
      ntmo = m_lk ? m_tmo : (d >> 8);
      nen = m_en | ((d >> 2) & 1);
      rl = ws && m_svc == 16'h5555 && d == 16'hAAAA && run;
      rq = 0; fire = 0; ocnt = m_cnt;
      if (wc) begin
        rq = (((d >> 4) & 1) == 0) || (((d >> 5) & 1) == 0) || (nen && ntmo == 0);
        if (((d >> 4) & 1) == 0) m_rc = 1;
        m_tmo = ntmo; m_en = nen; m_asrt = (d >> 5) & 1; m_lk = 1;
        m_cnt = ntmo + 1; m_div = 0;
        m_arm = nen && ntmo != 0 && m_ie && (ntmo + 1 > m_pre);
      end else if (rl) begin
        m_cnt = m_tmo + 1; m_div = 0;
        m_arm = m_ie && (m_tmo + 1 > m_pre);
      end else if (run && m_cnt > 0 && ref_tick) begin
        if (m_div == DIV - 1) begin
          m_div = 0; m_cnt--;
          if (m_arm && m_cnt == m_pre) begin fire = 1; m_arm = 0; end
          if (m_cnt == 0) begin m_rc = 2; rq = 1; end
        end else m_div++;
      end
      if (wi) begin
        if (!m_ilk) begin m_ie = (d >> 15) & 1; m_pre = d & 255; end
        m_ilk = 1;
        m_arm = run && m_ie && (ocnt > m_pre);
      end
      if (fire) m_ist = 1;
      else if (wi && ((d >> 14) & 1)) m_ist = 0;
      if (ws) m_svc = d;
      if (wm) m_pde = d & 1;
      m_rq = rq;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h at cycle %0d", req, what, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    chk(cur_req, $sformatf("rdata[%h]", addr), int'(rdata), m_read(int'(addr)));
    chk(cur_req, "irq", int'(irq), m_ist);
    chk(cur_req, "rst_req", int'(rst_req), m_rq);
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); addr = 4'((k % 6) * 2);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic peek(input logic [3:0] a, string req, int exp);
    @(negedge clk); addr = a;
    @(posedge clk); #(CLK_PERIOD/4);
    chk(req, "direct read", int'(rdata), exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    do_reset();
    cur_req = "R1";
    peek(4'h0, "R1", 16'h0030);
    peek(4'h6, "R1", 16'h0004);
    peek(4'h8, "R1", 16'h0001);
    idle(7);

    cur_req = "R10";
    wr(4'h3, 16'hFFFF);
    wr(4'hC, 16'hFFFF);
    wr(4'h8, 16'hFFFE);
    peek(4'h8, "R10", 16'h0000);
    peek(4'hE, "R10", 16'h0000);
    idle(6);

    do_reset();
    cur_req = "R9";
    wr(4'h6, 16'h8002);
    wr(4'h6, 16'h0005);
    peek(4'h6, "R9", 16'h8002);
    cur_req = "R2";
    wr(4'h0, 16'h0534);
    idle(8);
    cur_req = "R3";
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    peek(4'h2, "R3", 16'hAAAA);
    cur_req = "R8";
    idle(24);
    peek(4'h6, "R8", 16'hC002);
    cur_req = "R9";
    wr(4'h6, 16'h4000);
    peek(4'h6, "R9", 16'h8002);
    cur_req = "R7";
    idle(12);
    peek(4'h4, "R7", 16'h0002);
    wr(4'h4, 16'hFFFF);
    peek(4'h4, "R7", 16'h0002);
    idle(4);

    do_reset();
    cur_req = "R4";
    wr(4'h0, 16'h0330);
    idle(10);
    wr(4'h0, 16'h0834);
    peek(4'h0, "R4", 16'h0334);
    wr(4'h0, 16'h0030);
    peek(4'h0, "R4", 16'h0334);
    cur_req = "R3";
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    idle(20);

    do_reset();
    cur_req = "R6";
    wr(4'h0, 16'h0034);
    idle(3);
    cur_req = "R5";
    wr(4'h0, 16'h0020);
    peek(4'h4, "R5", 16'h0001);
    peek(4'h0, "R5", 16'h0034);
    wr(4'h0, 16'h0014);
    idle(3);

    do_reset();
    cur_req = "R8";
    wr(4'h6, 16'h8009);
    wr(4'h0, 16'h0534);
    idle(34);
    peek(4'h6, "R8", 16'h8009);

    finish_run();
  end
endmodule